// File: doc/BRIEF.md
# Tick-Driven Watchdog with Reset/Interrupt Steering

This block is a one-shot watchdog that counts down on a slow periodic tick (nominally 16 Hz, so one tick is 1/16 s). Software arms it by writing a single configuration byte. The low bits of that byte choose a power-of-four resolution, the middle bits hold a multiplier, and the top bit decides the action taken at expiry. Every access to the configuration byte, whether a write or a strobed read, restarts the countdown. No other register access does this.

When the countdown completes, the block raises a sticky expiry flag. If the steering bit is set, it issues a one-cycle system reset request, clears the configuration byte so that the watchdog stays disarmed, and clears the century bit of a companion byte. If the steering bit is clear, it issues a one-cycle interrupt pulse instead, keeps the configuration, and stays idle until the next access. A small byte port gives access to the configuration byte, a read-only flag byte and the companion byte. Read data follows the address combinationally. The read strobe marks an access.

Top module: `wdt_steer`

## Requirements
- R1: After reset, the configuration byte, the flag and the companion byte read 0x00, and the reset-request and interrupt outputs are low.
- R2: Address 0 is the configuration byte. Bits [1:0] are the resolution code c and bits [6:2] are the multiplier m. The timeout is m·4^c ticks. The expiry output appears one clock after the tick that completes the count.
- R3: A configuration value with m = 0 (including 0x00) disables the watchdog, and no expiry ever occurs.
- R4: A write to the configuration byte stores the value, reloads the countdown with the new timeout and clears the expiry flag.
- R5: A strobed read of the configuration byte restarts the countdown from the stored value and leaves the expiry flag unchanged.
- R6: On expiry, the flag output goes high and stays high. Bit 7 of the flag byte at address 1 reads the same flag, and its other bits read 0.
- R7: If configuration bit 7 is set at expiry, the reset request is high for exactly one cycle, the interrupt stays low, the configuration byte becomes 0x00 and stays disarmed, and bit 6 of the companion byte at address 2 is cleared with its other bits kept.
- R8: If configuration bit 7 is clear at expiry, the interrupt is high for exactly one cycle, the reset request stays low, the configuration is retained, and no further expiry occurs without a new access.
- R9: Writes to the flag byte and to address 3 have no effect, and address 3 reads 0x00.
- R10: A configuration access in the same cycle as a tick wins: the countdown is reloaded, and that tick neither decrements nor expires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per 1/16 s |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| wd_flag_o | output | 1 | Sticky expiry flag |

## Verification
The bench targets off-by-one timing: a design that expired one tick early or late would pulse at the wrong tick of a directed or randomly drawn timeout. It arms the watchdog with a zero multiplier under every code, so a design that treated only 0x00 as disabled would fire. It kicks with a read and with a write while a tick arrives on the last count, so a design that let the tick win would pulse. A design that cleared the flag on a read or re-armed after an expiry would be caught by flag reads and by long idle tick runs after each expiry. The reset path is checked for clearing the configuration and only the century bit of the companion byte.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_FLAGS = 2'd1,
        SEL_AUX   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/wdt_span_calc.sv
module wdt_span_calc #(
    parameter int CODE_W = 2,
    parameter int MULT_W = 5,
    parameter int CNT_W  = MULT_W + 2 * ((1 << CODE_W) - 1)
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic [CNT_W-1:0]  ticks_o
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] cand [NUM_CODES];

    // one shifted copy of the multiplier per resolution step
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_step
        assign cand[g] = CNT_W'(mult_i) << (2 * g);
    end

    always_comb begin
        ticks_o = cand[code_i];
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            expire_o = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/wdt_regbank.sv
module wdt_regbank
    import wdt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 2,
    parameter int MULT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              expire_i,
    output logic              kick_o,
    output logic [CODE_W-1:0] kick_code_o,
    output logic [MULT_W-1:0] kick_mult_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic              rst_req_o,
    output logic              irq_o,
    output logic              flag_o
);
    localparam int STEER_POS = DATA_W - 1;
    localparam int FLAG_POS  = DATA_W - 1;
    localparam int CENT_POS  = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] aux;
        logic              flag;
        logic              rst_req;
        logic              irq;
    } bank_state_t;

    bank_state_t st_d, st_q;
    reg_sel_e    sel;
    logic        cfg_wr;
    logic [DATA_W-1:0] kick_val;

    assign sel    = reg_sel_e'(addr_i);
    assign cfg_wr = wr_i && (sel == SEL_CFG);
    assign kick_o = (wr_i || rd_i) && (sel == SEL_CFG);

    always_comb begin
        kick_val    = cfg_wr ? wdata_i : st_q.cfg;
        kick_code_o = kick_val[CODE_W-1:0];
        kick_mult_o = kick_val[CODE_W+MULT_W-1:CODE_W];
    end

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        st_d.irq     = 1'b0;
        if (wr_i) begin
            unique case (sel)
                SEL_CFG: begin
                    st_d.cfg  = wdata_i;
                    st_d.flag = 1'b0;
                end
                SEL_AUX:   st_d.aux = wdata_i;
                default: ;
            endcase
        end
        if (expire_i) begin
            st_d.flag = 1'b1;
            if (st_q.cfg[STEER_POS]) begin
                st_d.rst_req       = 1'b1;
                st_d.cfg           = '0;
                st_d.aux[CENT_POS] = 1'b0;
            end else begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_CFG:   rdata_o = st_q.cfg;
            SEL_FLAGS: rdata_o[FLAG_POS] = st_q.flag;
            SEL_AUX:   rdata_o = st_q.aux;
            default:   rdata_o = '0;
        endcase
    end

    assign cfg_o     = st_q.cfg;
    assign rst_req_o = st_q.rst_req;
    assign irq_o     = st_q.irq;
    assign flag_o    = st_q.flag;
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 2,
    parameter int MULT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              sys_rst_req_o,
    output logic              irq_o,
    output logic              wd_flag_o
);
    localparam int CNT_W = MULT_W + 2 * ((1 << CODE_W) - 1);

    logic              kick_w;
    logic [CODE_W-1:0] kick_code_w;
    logic [MULT_W-1:0] kick_mult_w;
    logic [CNT_W-1:0]  span_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] cfg_w;
    logic              expire_w;

    wdt_regbank #(.DATA_W(DATA_W), .CODE_W(CODE_W), .MULT_W(MULT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr_i),
        .rd_i        (reg_rd_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .expire_i    (expire_w),
        .kick_o      (kick_w),
        .kick_code_o (kick_code_w),
        .kick_mult_o (kick_mult_w),
        .cfg_o       (cfg_w),
        .rst_req_o   (sys_rst_req_o),
        .irq_o       (irq_o),
        .flag_o      (wd_flag_o)
    );

    wdt_span_calc #(.CODE_W(CODE_W), .MULT_W(MULT_W), .CNT_W(CNT_W)) u_span (
        .code_i  (kick_code_w),
        .mult_i  (kick_mult_w),
        .ticks_o (span_w)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (kick_w),
        .load_val_i (span_w),
        .tick_i     (tick_i),
        .expire_o   (expire_w),
        .count_o    (cnt_w)
    );
endmodule

// File: rtl/wdt_steer_checker.sv
module wdt_steer_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [1:0]        reg_addr_i,
    input logic              sys_rst_req_o,
    input logic              irq_o,
    input logic              wd_flag_o,
    input logic [DATA_W-1:0] cfg_q,
    input logic [CNT_W-1:0]  cnt_q
);
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_req_o && irq_o));

    assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> (cfg_q == '0));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req_o || irq_o) |-> wd_flag_o);

    assert_wr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd0) |=> !wd_flag_o);

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |=> !(sys_rst_req_o || irq_o));

    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_access_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (reg_wr_i || reg_rd_i) && reg_addr_i == 2'd0) |=> !(sys_rst_req_o || irq_o));
endmodule

bind wdt_steer wdt_steer_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .reg_wr_i      (reg_wr_i),
    .reg_rd_i      (reg_rd_i),
    .reg_addr_i    (reg_addr_i),
    .sys_rst_req_o (sys_rst_req_o),
    .irq_o         (irq_o),
    .wd_flag_o     (wd_flag_o),
    .cfg_q         (cfg_w),
    .cnt_q         (cnt_w)
);

// File: tb/wdt_steer_bench.sv
`timescale 1ns/1ps
module wdt_steer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rst_req, irq, flag;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    wdt_steer u_wdt_steer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .sys_rst_req_o(rst_req), .irq_o(irq), .wd_flag_o(flag)
    );

    function automatic int exp_ticks(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic run_ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (irq || rst_req) pulses++;
        end
    endtask

    // arm, run to one short of timeout, then the final tick
    task automatic arm_and_expire(input string req, input logic [7:0] v);
        int p;
        reg_write(2'd0, v);
        run_ticks(exp_ticks(v) - 1, p);
        check({req, " no early pulse"}, p, 0);
        run_ticks(1, p);
        check({req, " pulse on last tick"}, p, 1);
        check({req, " reset request"}, rst_req, v[7]);
        check({req, " interrupt"}, irq, !v[7]);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, d); check("R1 cfg", d, 8'h00);
        peek(2'd1, d); check("R1 flags", d, 8'h00);
        peek(2'd2, d); check("R1 aux", d, 8'h00);
        check("R1 rst_req", rst_req, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 flag", flag, 1'b0);

        // R2 R8 interrupt path, code 1 mult 1 -> 4 ticks
        arm_and_expire("R2 R8 0x05", 8'h05);
        check("R6 flag out", flag, 1'b1);
        @(negedge clk);
        check("R8 irq one cycle", irq, 1'b0);
        peek(2'd0, d); check("R8 cfg kept", d, 8'h05);
        run_ticks(40, p); check("R8 no re-arm", p, 0);
        peek(2'd1, d); check("R6 flags byte", d, 8'h80);

        // R5 read restarts, flag kept
        reg_read(2'd0, d);
        check("R5 flag kept after read", flag, 1'b1);
        run_ticks(3, p); check("R5 no early pulse", p, 0);
        run_ticks(1, p); check("R5 pulse after read kick", p, 1);

        // R4 write clears flag and reloads mid-count
        reg_write(2'd0, 8'h09);
        check("R4 flag cleared", flag, 1'b0);
        run_ticks(5, p);
        reg_write(2'd0, 8'h05);
        run_ticks(3, p); check("R4 reload no early", p, 0);
        run_ticks(1, p); check("R4 reload pulse", p, 1);

        // R10 write coincident with tick on last count
        reg_write(2'd0, 8'h04);
        addr = 2'd0; wdata = 8'h04; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        check("R10 write beats tick", irq, 1'b0);
        run_ticks(1, p); check("R10 pulse after write kick", p, 1);
        // R10 read coincident with tick
        reg_write(2'd0, 8'h04);
        addr = 2'd0; rd = 1'b1; tick = 1'b1;
        @(negedge clk);
        rd = 1'b0; tick = 1'b0;
        check("R10 read beats tick", irq, 1'b0);
        run_ticks(1, p); check("R10 pulse after read kick", p, 1);

        // R3 disabled values
        reg_write(2'd0, 8'h00);
        run_ticks(100, p); check("R3 zero disables", p, 0);
        for (int c = 0; c < 4; c++) begin
            reg_write(2'd0, 8'h80 | 8'(c));
            run_ticks(200, p); check("R3 mult zero disables", p, 0);
        end

        // R7 reset path
        reg_write(2'd2, 8'h5A);
        arm_and_expire("R7 0x86", 8'h86);
        check("R7 flag", flag, 1'b1);
        peek(2'd0, d); check("R7 cfg cleared", d, 8'h00);
        peek(2'd2, d); check("R7 century cleared", d, 8'h1A);
        @(negedge clk);
        check("R7 rst one cycle", rst_req, 1'b0);
        run_ticks(80, p); check("R7 stays disarmed", p, 0);

        // R9 read-only flag byte and spare address
        reg_write(2'd1, 8'h00);
        peek(2'd1, d); check("R9 flags write ignored", d, 8'h80);
        check("R9 flag out kept", flag, 1'b1);
        reg_write(2'd3, 8'hFF);
        peek(2'd3, d); check("R9 spare reads zero", d, 8'h00);
        peek(2'd2, d); check("R9 aux untouched", d, 8'h1A);

        // R2 R7 R8 random configurations
        for (int t = 0; t < 14; t++) begin
            logic [7:0] v;
            v = {1'($urandom_range(0, 1)), 5'($urandom_range(1, 31)), 2'($urandom_range(0, 3))};
            arm_and_expire("R2 random", v);
            peek(2'd0, d);
            check("R2 random cfg after", d, v[7] ? 8'h00 : v);
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule